// File: doc/BRIEF.md
# PLL Safe Reprogramming Sequencer

This block changes the multiplier (N), reference divider (M) and post divider (PL) of a clock PLL without letting the output clock glitch or overshoot. It owns the PLL control fields and drives them directly: enable, power-down (IDDQ), lock-detector-off, the bypass/VCO output select, the output VCO divider field and the coefficient word. It cooperates with an external ramp agent that moves the running N to a new value gradually.

When only N moves, the block asks the ramp agent for a glide to the new N and leaves the loop running. When M or PL moves, it first glides down to the N that gives the minimum VCO frequency. It then halves the output divider and drops into bypass. It powers up and disables the PLL, writes the new coefficients and enables it again. After waiting for lock it reselects the VCO, restores the divider and glides up to the final N. If an attempt with gliding fails, the whole sequence is retried once without gliding. An orderly shutdown request glides down to the minimum-VCO N, selects bypass and then disables the PLL.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset the enable is 0, IDDQ is 1, lock-detect-off is 1, the output select is 0 (bypass), the divider field and all coefficient fields are 0, and busy, done and error are 0.
- R2: With gliding allowed, the PLL enabled and the requested M and PL equal to the current ones, the only action is a glide to the requested N; the PLL is never disabled, and a request with an unchanged N completes with no glide.
- R3: A glide writes its target into the N field in the same cycle that ramp_en_o rises, holds ramp_en_o until ramp_done_i, occurs only while the PLL is enabled, and is skipped when the N field already equals the target.
- R4: The minimum N for a given M is ceil(M * VCO_MIN_MHZ / REF_MHZ), saturated at 255 (with defaults 1000 and 26: M=1 gives 39, M=3 gives 116, M=7 gives 255); a full reprogram with gliding allowed on an enabled PLL first glides to the minimum N of the old M.
- R5: During a full reprogram the divider field is 2 when bypass (select 0) is entered and still 2 when the VCO is reselected; it returns to 0 afterwards.
- R6: IDDQ is cleared and the PLL disabled before the coefficients are written; M and PL change only while the PLL is disabled; when the PLL is enabled the N field equals the minimum N of the new M if gliding, else the requested N.
- R7: After enabling, lock-detect-off is cleared and the lock input is awaited for at most CLK_MHZ*LOCK_US cycles; the VCO is reselected only after lock, followed by a glide up to the requested N when gliding.
- R8: A lock timeout or a glide timeout (RAMP_CYC cycles) in a gliding attempt starts one retry without gliding, which writes the requested N directly.
- R9: A failure in a non-gliding attempt ends the request with a one-cycle error pulse and no done pulse.
- R10: Shutdown glides to the minimum N of the current M if the PLL is enabled, then selects bypass, then clears the enable; a glide timeout during shutdown does not stop it.
- R11: Busy is high from the cycle after an accepted request until the done or error pulse; done and error are one-cycle pulses, never together with busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to apply new coefficients (pulse, taken when idle) |
| shutdown_i | input | 1 | Request for orderly shutdown (pulse, taken when idle, start wins) |
| ramp_allow_i | input | 1 | Gliding permitted for this request |
| new_m_i | input | MW | Requested M |
| new_n_i | input | NW | Requested N |
| new_pl_i | input | PW | Requested PL |
| pll_lock_i | input | 1 | Lock indication from the PLL |
| ramp_done_i | input | 1 | Glide finished, from the ramp agent |
| pll_en_o | output | 1 | PLL enable |
| pll_iddq_o | output | 1 | PLL power-down |
| lock_det_off_o | output | 1 | Lock detector disable |
| vco_sel_o | output | 1 | Output select: 1 VCO, 0 bypass |
| vco_div_o | output | DW | Output VCO divider field |
| coeff_m_o | output | MW | M field |
| coeff_n_o | output | NW | N field (glide target while ramp_en_o) |
| coeff_pl_o | output | PW | PL field |
| ramp_en_o | output | 1 | Glide request to the ramp agent |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished (pulse) |
| err_o | output | 1 | Sequence failed (pulse) |

## Verification
The assertions take for granted that start and shutdown arrive only as requests sampled in the idle state, and that the ramp agent raises ramp_done_i only while ramp_en_o is high and drops it when ramp_en_o falls. The bench models a PLL that locks a fixed number of cycles after being enabled with the detector on, and a ramp agent that answers after a few cycles. It withholds lock for a chosen number of enable attempts or withholds the glide answer to drive the timeout paths. It sweeps M and PL over a small grid, predicts every glide target and enable-time N arithmetically, and compares them with what appears at the ports.

// File: rtl/pllseq_pkg.sv
// Package: shared state encoding of the PLL reprogramming sequencer.
package pllseq_pkg;

    typedef enum logic [4:0] {
        S_IDLE,
        S_CHECK,
        S_RAMP,
        S_DIV2,
        S_BYP,
        S_IDDQ,
        S_DIS,
        S_COEF,
        S_EN,
        S_LDO,
        S_LOCKW,
        S_VCO,
        S_DIV1,
        S_FAIL,
        S_SDBYP,
        S_SDDIS,
        S_DONE,
        S_ERR
    } seq_state_t;

endpackage

// File: rtl/pllseq_nmin.sv
// Minimum-VCO N calculator.
// Computes ceil(M * VCO_MIN_MHZ / REF_MHZ) and saturates it to the N field.
// Assumes REF_MHZ > 0 and that M * VCO_MIN_MHZ fits in 32 bits.
module pllseq_nmin #(
    parameter int MW          = 8,
    parameter int NW          = 8,
    parameter int VCO_MIN_MHZ = 1000,
    parameter int REF_MHZ     = 26
) (
    input  logic [MW-1:0] m_i,
    output logic [NW-1:0] n_o
);

    localparam logic [31:0] NMAX = 32'((1 << NW) - 1);

    logic [31:0] prod;
    logic [31:0] quo;

    // Rounded-up division followed by saturation to the field width.
    always_comb begin
        prod = 32'(m_i) * 32'(VCO_MIN_MHZ);
        quo  = (prod + 32'(REF_MHZ) - 32'd1) / 32'(REF_MHZ);
        n_o  = (quo > NMAX) ? NMAX[NW-1:0] : quo[NW-1:0];
    end

endmodule

// File: rtl/pllseq_timer.sv
// Wait-window timer.
// Counts while run_i is high and flags when the count reaches limit_i.
// Clears whenever run_i is low. Assumes limit_i is stable during a window.
module pllseq_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic [CW-1:0] limit_i,
    output logic          expired_o
);

    logic [CW-1:0] cnt_q;

    // Count up inside a window and stop at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (!expired_o) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // Window exhausted.
    always_comb expired_o = (cnt_q >= limit_i);

endmodule

// File: rtl/pll_reprog_seq.sv
// PLL safe reprogramming sequencer (top).
// Applies a new M/N/PL triple with glides, bypass, power-up and lock wait.
// Runs one retry without gliding if a gliding attempt fails.
// Also performs an orderly shutdown.
// Assumes start/shutdown are sampled only when idle and that ramp_done_i is
// asserted by the ramp agent only while ramp_en_o is high.
module pll_reprog_seq
    import pllseq_pkg::*;
#(
    parameter int MW          = 8,
    parameter int NW          = 8,
    parameter int PW          = 6,
    parameter int DW          = 6,
    parameter int CLK_MHZ     = 100,
    parameter int LOCK_US     = 300,
    parameter int RAMP_CYC    = 500,
    parameter int VCO_MIN_MHZ = 1000,
    parameter int REF_MHZ     = 26
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          shutdown_i,
    input  logic          ramp_allow_i,
    input  logic [MW-1:0] new_m_i,
    input  logic [NW-1:0] new_n_i,
    input  logic [PW-1:0] new_pl_i,
    input  logic          pll_lock_i,
    input  logic          ramp_done_i,
    output logic          pll_en_o,
    output logic          pll_iddq_o,
    output logic          lock_det_off_o,
    output logic          vco_sel_o,
    output logic [DW-1:0] vco_div_o,
    output logic [MW-1:0] coeff_m_o,
    output logic [NW-1:0] coeff_n_o,
    output logic [PW-1:0] coeff_pl_o,
    output logic          ramp_en_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o
);

    localparam int LOCK_CYC = CLK_MHZ * LOCK_US;
    localparam int TMAX     = (LOCK_CYC > RAMP_CYC) ? LOCK_CYC : RAMP_CYC;
    localparam int TW       = $clog2(TMAX + 1);

    seq_state_t    st_q, ramp_ret_q;
    logic [MW-1:0] tm_q;
    logic [NW-1:0] tn_q;
    logic [PW-1:0] tpl_q;
    logic          slide_q;
    logic          en_q, iddq_q, ldo_q, sel_q;
    logic [DW-1:0] div_q;
    logic [MW-1:0] cm_q;
    logic [NW-1:0] cn_q;
    logic [PW-1:0] cpl_q;

    logic [NW-1:0] nmin_old, nmin_new;
    logic          tmr_run, tmr_exp;
    logic [TW-1:0] tmr_limit;
    logic          r_req;
    logic [NW-1:0] r_tgt;
    seq_state_t    r_ret;

    // Minimum-VCO N for the running M and for the requested M.
    pllseq_nmin #(.MW(MW), .NW(NW), .VCO_MIN_MHZ(VCO_MIN_MHZ), .REF_MHZ(REF_MHZ))
        u_nmin_old (.m_i(cm_q), .n_o(nmin_old));
    pllseq_nmin #(.MW(MW), .NW(NW), .VCO_MIN_MHZ(VCO_MIN_MHZ), .REF_MHZ(REF_MHZ))
        u_nmin_new (.m_i(tm_q), .n_o(nmin_new));

    // Shared window timer for the lock wait and the glide wait.
    always_comb begin
        tmr_run   = (st_q == S_LOCKW) || (st_q == S_RAMP);
        tmr_limit = (st_q == S_LOCKW) ? TW'(LOCK_CYC) : TW'(RAMP_CYC);
    end

    pllseq_timer #(.CW(TW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (tmr_run),
        .limit_i   (tmr_limit),
        .expired_o (tmr_exp)
    );

    // Decide whether this state requests a glide, its target and its return.
    always_comb begin
        r_req = 1'b0;
        r_tgt = cn_q;
        r_ret = S_DONE;
        case (st_q)
            S_IDLE: if (!start_i && shutdown_i && en_q) begin
                r_req = 1'b1; r_tgt = nmin_old; r_ret = S_SDBYP;
            end
            S_CHECK: if (slide_q && en_q && tm_q == cm_q && tpl_q == cpl_q) begin
                r_req = 1'b1; r_tgt = tn_q; r_ret = S_DONE;
            end else if (slide_q && en_q) begin
                r_req = 1'b1; r_tgt = nmin_old; r_ret = S_DIV2;
            end
            S_DIV1: if (slide_q) begin
                r_req = 1'b1; r_tgt = tn_q; r_ret = S_DONE;
            end
            default: ;
        endcase
    end

    // Sequencer state and PLL control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= S_IDLE;
            ramp_ret_q <= S_DONE;
            tm_q       <= '0;
            tn_q       <= '0;
            tpl_q      <= '0;
            slide_q    <= 1'b0;
            en_q       <= 1'b0;
            iddq_q     <= 1'b1;
            ldo_q      <= 1'b1;
            sel_q      <= 1'b0;
            div_q      <= '0;
            cm_q       <= '0;
            cn_q       <= '0;
            cpl_q      <= '0;
        end else begin
            case (st_q)
                S_IDLE: begin
                    if (start_i) begin
                        tm_q    <= new_m_i;
                        tn_q    <= new_n_i;
                        tpl_q   <= new_pl_i;
                        slide_q <= ramp_allow_i;
                        st_q    <= S_CHECK;
                    end else if (shutdown_i) begin
                        st_q <= S_SDBYP;
                    end
                end
                S_CHECK: st_q <= S_DIV2;
                S_RAMP: begin
                    if (ramp_done_i) st_q <= ramp_ret_q;
                    else if (tmr_exp) st_q <= (ramp_ret_q == S_SDBYP) ? S_SDBYP : S_FAIL;
                end
                S_DIV2:  begin div_q  <= DW'(2); st_q <= S_BYP;  end
                S_BYP:   begin sel_q  <= 1'b0;   st_q <= S_IDDQ; end
                S_IDDQ:  begin iddq_q <= 1'b0;   st_q <= S_DIS;  end
                S_DIS:   begin en_q   <= 1'b0;   st_q <= S_COEF; end
                S_COEF: begin
                    cm_q  <= tm_q;
                    cpl_q <= tpl_q;
                    cn_q  <= slide_q ? nmin_new : tn_q;
                    st_q  <= S_EN;
                end
                S_EN:    begin en_q  <= 1'b1; st_q <= S_LDO; end
                S_LDO:   begin ldo_q <= 1'b0; st_q <= S_LOCKW; end
                S_LOCKW: begin
                    if (pll_lock_i) st_q <= S_VCO;
                    else if (tmr_exp) st_q <= S_FAIL;
                end
                S_VCO:   begin sel_q <= 1'b1; st_q <= S_DIV1; end
                S_DIV1:  begin div_q <= '0;   st_q <= S_DONE; end
                S_FAIL: begin
                    if (slide_q) begin
                        slide_q <= 1'b0;
                        st_q    <= S_CHECK;
                    end else begin
                        st_q <= S_ERR;
                    end
                end
                S_SDBYP: begin sel_q <= 1'b0; st_q <= S_SDDIS; end
                S_SDDIS: begin en_q  <= 1'b0; st_q <= S_DONE;  end
                default: st_q <= S_IDLE;
            endcase
            if (r_req) begin
                if (cn_q == r_tgt) begin
                    st_q <= r_ret;
                end else begin
                    cn_q       <= r_tgt;
                    ramp_ret_q <= r_ret;
                    st_q       <= S_RAMP;
                end
            end
        end
    end

    // Port mapping of the held fields and status.
    always_comb begin
        pll_en_o       = en_q;
        pll_iddq_o     = iddq_q;
        lock_det_off_o = ldo_q;
        vco_sel_o      = sel_q;
        vco_div_o      = div_q;
        coeff_m_o      = cm_q;
        coeff_n_o      = cn_q;
        coeff_pl_o     = cpl_q;
        ramp_en_o      = (st_q == S_RAMP);
        done_o         = (st_q == S_DONE);
        err_o          = (st_q == S_ERR);
        busy_o         = !(st_q == S_IDLE || st_q == S_DONE || st_q == S_ERR);
    end

    AST_RAMP_WHILE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_en_o |-> pll_en_o);  // R3
    AST_VCO_DIV_HALVED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vco_sel_o) |-> (vco_div_o == DW'(2)));  // R5
    AST_COEF_ONLY_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(coeff_m_o) || !$stable(coeff_pl_o)) |-> !pll_en_o);  // R6
    AST_VCO_AFTER_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vco_sel_o) |-> (pll_en_o && !lock_det_off_o));  // R7
    AST_DISABLE_IN_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_en_o) |-> !vco_sel_o);  // R10
    AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy_o, done_o, err_o}));  // R11

endmodule

// File: tb/pll_reprog_seq_tb_top.sv
module pll_reprog_seq_tb_top;

    localparam int REF  = 26;
    localparam int VMIN = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, shutdown = 1'b0, allow = 1'b0;
    logic [7:0] nm = '0, nn = '0;
    logic [5:0] npl = '0;
    logic lock = 1'b0, rdone = 1'b0;
    logic en, iddq, ldo, sel, ren, busy, done, err;
    logic [5:0] div, cpl;
    logic [7:0] cm, cn;

    int checks = 0, fails = 0;
    int rt[256];
    int rc = 0, enr = 0, en_n = -1, bad_dis = 0, bad_div = 0;
    int fail_goal = 0;
    bit ramp_ok = 1'b1, prog_mode = 1'b0, attempt_bad = 1'b0;
    int lcnt = 0, rcnt = 0;

    // Expected-state model.
    int bm = 0, bn = 0, bpl = 0, bdiv = 0;
    bit ben = 1'b0, bsel = 1'b0;
    int xr[8];
    int xrc = 0, xenr = 0, xen_n = -1;

    always #5 clk = ~clk;

    pll_reprog_seq #(.LOCK_US(1), .RAMP_CYC(50), .VCO_MIN_MHZ(VMIN), .REF_MHZ(REF)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .shutdown_i(shutdown),
        .ramp_allow_i(allow), .new_m_i(nm), .new_n_i(nn), .new_pl_i(npl),
        .pll_lock_i(lock), .ramp_done_i(rdone), .pll_en_o(en), .pll_iddq_o(iddq),
        .lock_det_off_o(ldo), .vco_sel_o(sel), .vco_div_o(div), .coeff_m_o(cm),
        .coeff_n_o(cn), .coeff_pl_o(cpl), .ramp_en_o(ren), .busy_o(busy),
        .done_o(done), .err_o(err));

    function automatic int nmin(int m);
        int q = (m * VMIN + REF - 1) / REF;
        return (q > 255) ? 255 : q;
    endfunction

    // Monitor plus PLL and ramp-agent models, all on the falling edge.
    initial begin
        bit p_ren = 1'b0, p_en = 1'b0, p_sel = 1'b0;
        forever begin
            @(negedge clk);
            if (ren && !p_ren) begin
                rt[rc % 256] = int'(cn);
                rc++;
            end
            if (en && !p_en) begin
                enr++;
                en_n = int'(cn);
                attempt_bad = (enr <= fail_goal);
            end
            if (!en && p_en && sel) bad_dis++;
            if (prog_mode && sel != p_sel && div != 6'd2) bad_div++;
            if (en && !ldo && !attempt_bad) lcnt++; else lcnt = 0;
            lock = (lcnt >= 20);
            if (ren) rcnt++; else rcnt = 0;
            rdone = ramp_ok && ren && (rcnt >= 5);
            p_ren = ren; p_en = en; p_sel = sel;
        end
    end

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R11 watchdog: actual hung, expected completion");
        report();
        $finish;
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic push(int t);
        if (xrc < 8) xr[xrc] = t;
        xrc++;
    endtask

    // One modelled attempt of the sequence.
    task automatic attempt(int m, int n, int pl, bit slide, bit rok,
                           inout int lf, output bit ok);
        int t;
        ok = 1'b1;
        if (slide && ben && m == bm && pl == bpl) begin
            if (n != bn) begin push(n); bn = n; if (!rok) ok = 1'b0; end
            return;
        end
        if (slide && ben) begin
            t = nmin(bm);
            if (t != bn) begin
                push(t); bn = t;
                if (!rok) begin ok = 1'b0; return; end
            end
        end
        bdiv = 2; bsel = 1'b0; ben = 1'b1; bm = m; bpl = pl;
        bn = slide ? nmin(m) : n;
        xenr++; xen_n = bn;
        if (lf > 0) begin lf--; ok = 1'b0; return; end
        bsel = 1'b1; bdiv = 0;
        if (slide && bn != n) begin push(n); bn = n; if (!rok) ok = 1'b0; end
    endtask

    task automatic wait_end(output bit got_done, output bit got_err);
        got_done = 1'b0; got_err = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (done || err) begin
                got_done = done; got_err = err;
                chk("R11 busy during pulse", int'(busy), 0);
                break;
            end
        end
        @(negedge clk);
    endtask

    task automatic common_checks(int rc0, int enr0, int bd0, int bv0);
        chk("R3 R4 R2 glide count", rc - rc0, xrc);
        for (int i = 0; i < xrc && i < 8; i++)
            chk("R3 R4 glide target", rt[(rc0 + i) % 256], xr[i]);
        chk("R6 R8 enable count", enr - enr0, xenr);
        if (xenr > 0) chk("R6 R4 N at enable", en_n, xen_n);
        chk("R10 R6 disable in bypass", bad_dis - bd0, 0);
        chk("R5 divider at select change", bad_div - bv0, 0);
        chk("R6 M field", int'(cm), bm);
        chk("R3 N field", int'(cn), bn);
        chk("R6 PL field", int'(cpl), bpl);
        chk("R10 enable", int'(en), int'(ben));
        chk("R7 select", int'(sel), int'(bsel));
        chk("R5 divider", int'(div), bdiv);
        chk("R11 idle busy", int'(busy), 0);
    endtask

    task automatic run_prog(int m, int n, int pl, bit al, int lfail, bit rok);
        int rc0 = rc, enr0 = enr, bd0 = bad_dis, bv0 = bad_div;
        int lf = lfail;
        bit ok, gd, ge;
        xrc = 0; xenr = 0; xen_n = -1;
        attempt(m, n, pl, al, rok, lf, ok);
        if (!ok && al) attempt(m, n, pl, 1'b0, rok, lf, ok);
        fail_goal = enr + lfail;
        ramp_ok = rok;
        prog_mode = 1'b1;
        nm = 8'(m); nn = 8'(n); npl = 6'(pl); allow = al;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R11 busy after start", int'(busy), 1);
        wait_end(gd, ge);
        chk("R9 R8 error pulse", int'(ge), int'(!ok));
        chk("R9 R11 done pulse", int'(gd), int'(ok));
        chk("R6 IDDQ cleared", int'(iddq), 0);
        chk("R7 lock detect on", int'(ldo), 0);
        common_checks(rc0, enr0, bd0, bv0);
    endtask

    task automatic run_shutdown(bit rok);
        int rc0 = rc, enr0 = enr, bd0 = bad_dis, bv0 = bad_div;
        bit gd, ge;
        xrc = 0; xenr = 0; xen_n = -1;
        if (ben && nmin(bm) != bn) begin push(nmin(bm)); bn = nmin(bm); end
        ben = 1'b0; bsel = 1'b0;
        ramp_ok = rok;
        prog_mode = 1'b0;
        shutdown = 1'b1;
        @(negedge clk);
        shutdown = 1'b0;
        chk("R11 busy after shutdown", int'(busy), 1);
        wait_end(gd, ge);
        chk("R10 shutdown done", int'(gd), 1);
        chk("R10 shutdown no error", int'(ge), 0);
        common_checks(rc0, enr0, bd0, bv0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 enable", int'(en), 0);
        chk("R1 IDDQ", int'(iddq), 1);
        chk("R1 lock detect off", int'(ldo), 1);
        chk("R1 select", int'(sel), 0);
        chk("R1 divider", int'(div), 0);
        chk("R1 coefficients", int'(cm) + int'(cn) + int'(cpl), 0);
        chk("R1 status", int'(busy) + int'(done) + int'(err), 0);

        run_prog(3, 200, 2, 1'b1, 0, 1'b1);          // R6 R7 from disabled
        for (int m = 1; m <= 6; m++) begin            // R4 R5 sweep
            for (int k = 0; k < 2; k++) begin
                int pl = (k == 0) ? 2 : 5;
                run_prog(m, 40 + 30 * m + pl, pl, 1'b1, 0, 1'b1);
            end
        end
        run_prog(bm, 150, bpl, 1'b1, 0, 1'b1);       // R2 N only
        run_prog(bm, 150, bpl, 1'b1, 0, 1'b1);       // R2 R3 unchanged N
        run_prog(2, 90, 3, 1'b0, 0, 1'b1);           // R6 gliding off
        run_prog(4, 120, 1, 1'b1, 1, 1'b1);          // R8 lock fails once
        run_prog(5, 60, 2, 1'b1, 0, 1'b0);           // R8 glide timeout
        run_prog(1, 77, 4, 1'b1, 2, 1'b1);           // R9 both attempts fail
        run_shutdown(1'b1);                          // R10
        run_prog(7, 100, 1, 1'b1, 0, 1'b1);          // R4 saturated minimum N
        run_shutdown(1'b0);                          // R10 glide timeout
        report();
        $finish;
    end

endmodule